// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The block watches an asynchronous event pin and, on each rising edge, records the value of a free-running 32-bit time counter that the surrounding logic supplies. Software sees a control word, a 16-bit status word and the captured time as two 16-bit halves on a word-addressed read/write bus. The status word carries a pending flag, an error flag and a saturating count of the events seen since the last clear. A level interrupt tells software that a capture is waiting.

Software selects between two capture policies. In the replacing policy, each new event overwrites the held time. In the holding policy, the first time is kept and later events only raise the error flag until software clears the status. Reading the status word freezes the current time in a shadow copy, and the two time words return that copy. Software can therefore read status, then low half, then high half, and get one coherent event even while new events keep arriving.

Top module: `evt_capture_unit`

## Requirements
- R1: After reset, irq is 0 and reads of offsets 0x08, 0x09, 0x0A and 0x0B all return 0.
- R2: The pin passes through two synchroniser flops followed by a rising-edge detector. The time stored is the time_in value present in the cycle in which the edge is detected, which is two clock edges after the first edge that samples the pin high. A pin held high counts as exactly one event.
- R3: The event count in status bits 7:0 goes up by one per event and stays at 255 instead of wrapping.
- R4: Status bit 8 (pending) is set by every captured event and stays set until software clears it.
- R5: With control bit 1 = 1 (replacing policy), an event that arrives while pending is set replaces the stored time and leaves status bit 9 at 0.
- R6: With control bit 1 = 0 (holding policy), an event that arrives while pending is set leaves the stored time unchanged and sets status bit 9 (error).
- R7: Any write to offset 0x09 sets status bits 9, 8 and 7:0 to zero. If an event is detected in the same cycle as the write, that event counts as the first one after the clear: pending = 1, count = 1, error = 0, and its time is stored.
- R8: A read of 0x09 returns the live status and copies the stored time into a shadow. Reads of 0x0A (bits 15:0) and 0x0B (bits 31:16) return that shadow until the next read of 0x09, whatever events occur in between.
- R9: irq is 1 exactly when pending is set and control bit 0 (interrupt enable) is 1. A status clear drops irq on the next cycle.
- R10: Offset 0x08 reads back control bits 1:0 with the other bits 0. Status bit 14 always reads 0, because only capture operation is provided. Every other offset reads 0. Read data appears on bus_rdata one clock edge after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 32 | Free-running time counter value |
| evt_pin | input | 1 | Asynchronous event pin, rising edge is an event |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Level interrupt: pending and enabled |

## Verification
Bad pending or error state shows up on irq one cycle after it forms, and in the status word at the next read. A wrong saturating count only shows once the count passes 255. A wrong capture policy or capture cycle shows up as a time value that differs from the bench's record by a whole number of counter steps, but only after the status read that freezes it. A shadow that fails to freeze can only be seen when an event is detected between the status read and the time reads. For that reason the bench fires events between those reads.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

  localparam int ST_PEND_BIT = 8;
  localparam int ST_ERR_BIT  = 9;
  localparam int ST_MODE_BIT = 14;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_STAT = 3'd2,
    SEL_TLO  = 3'd3,
    SEL_THI  = 3'd4
  } reg_sel_e;

  // Saturating increment with a caller-supplied ceiling.
  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] ceil);
    sat_inc = (v >= ceil) ? ceil : v + 16'd1;
  endfunction

  // Status word layout: err at 9, pending at 8, count in 7:0, mode bit 14 fixed 0.
  function automatic logic [15:0] pack_status(input logic pend, input logic err,
                                              input logic [7:0] cnt);
    logic [15:0] s;
    s = 16'h0000;
    s[7:0] = cnt;
    s[ST_PEND_BIT] = pend;
    s[ST_ERR_BIT]  = err;
    s[ST_MODE_BIT] = 1'b0;
    pack_status = s;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // chain[LAST-1] is the synchronised pin, chain[LAST] its previous value
  assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/evt_capture_core.sv
module evt_capture_core
  import evt_cap_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_edge,
  input  logic              clr,
  input  logic              ow_allow,
  input  logic [TIME_W-1:0] time_in,
  output logic              pend,
  output logic              err,
  output logic [CNT_W-1:0]  cnt,
  output logic [TIME_W-1:0] cap_time
);
  localparam logic [15:0] CNT_CEIL = 16'((1 << CNT_W) - 1);

  logic              b_pend, b_err;
  logic [CNT_W-1:0]  b_cnt;
  logic              n_pend, n_err;
  logic [CNT_W-1:0]  n_cnt;
  logic [TIME_W-1:0] n_time;

  always_comb begin
    // a clear is applied first, so an event in the same cycle survives it
    b_pend = clr ? 1'b0 : pend;
    b_err  = clr ? 1'b0 : err;
    b_cnt  = clr ? '0   : cnt;
    n_pend = b_pend;
    n_err  = b_err;
    n_cnt  = b_cnt;
    n_time = cap_time;
    if (evt_edge) begin
      n_cnt = CNT_W'(sat_inc(16'(b_cnt), CNT_CEIL));
      if (!b_pend || ow_allow) begin
        n_time = time_in;
        n_pend = 1'b1;
      end else begin
        n_err = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      err      <= 1'b0;
      cnt      <= '0;
      cap_time <= '0;
    end else begin
      pend     <= n_pend;
      err      <= n_err;
      cnt      <= n_cnt;
      cap_time <= n_time;
    end
  end
endmodule

// File: rtl/evt_reg_shadow.sv
module evt_reg_shadow
  import evt_cap_pkg::*;
#(
  parameter int                REG_W    = 16,
  parameter int                TIME_W   = 32,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 4'h8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 4'h9,
  parameter logic [ADDR_W-1:0] OFS_TLO  = 4'hA,
  parameter logic [ADDR_W-1:0] OFS_THI  = 4'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  live_status,
  input  logic [TIME_W-1:0] cap_time,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_en,
  output logic              ow_allow,
  output logic              clr_req,
  output logic              snap_take,
  output logic [REG_W-1:0]  snap_lo,
  output logic [REG_W-1:0]  snap_hi
);
  localparam int HI_W = TIME_W - REG_W;

  reg_sel_e   sel;
  logic       rd_acc, wr_acc;
  logic [1:0] ctrl_q;

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_STAT: sel = SEL_STAT;
      OFS_TLO:  sel = SEL_TLO;
      OFS_THI:  sel = SEL_THI;
      default:  sel = SEL_NONE;
    endcase
  end

  assign rd_acc    = bus_en & ~bus_we;
  assign wr_acc    = bus_en &  bus_we;
  assign clr_req   = wr_acc & (sel == SEL_STAT);
  assign snap_take = rd_acc & (sel == SEL_STAT);
  assign irq_en    = ctrl_q[0];
  assign ow_allow  = ctrl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= 2'b00;
    else if (wr_acc && sel == SEL_CTRL) ctrl_q <= bus_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_lo <= '0;
      snap_hi <= '0;
    end else if (snap_take) begin
      snap_lo <= cap_time[REG_W-1:0];
      snap_hi <= REG_W'(cap_time[TIME_W-1:REG_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (sel)
        SEL_CTRL: bus_rdata <= REG_W'(ctrl_q);
        SEL_STAT: bus_rdata <= live_status;
        SEL_TLO:  bus_rdata <= snap_lo;
        SEL_THI:  bus_rdata <= snap_hi;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  if (HI_W > REG_W || HI_W < 1) begin : g_bad_split
    initial $error("time width must be between REG_W+1 and 2*REG_W");
  end
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import evt_cap_pkg::*;
#(
  parameter int TIME_W      = 32,
  parameter int REG_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_in,
  input  logic              evt_pin,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  logic              evt_edge;
  logic              clr_req, snap_take;
  logic              irq_en, ow_allow;
  logic              st_pend, st_err;
  logic [CNT_W-1:0]  st_cnt;
  logic [TIME_W-1:0] cap_time;
  logic [REG_W-1:0]  live_status;
  logic [REG_W-1:0]  snap_lo, snap_hi;

  evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .rise(evt_edge)
  );

  evt_capture_core #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt_edge(evt_edge), .clr(clr_req),
    .ow_allow(ow_allow), .time_in(time_in),
    .pend(st_pend), .err(st_err), .cnt(st_cnt), .cap_time(cap_time)
  );

  assign live_status = REG_W'(pack_status(st_pend, st_err, 8'(st_cnt)));

  evt_reg_shadow #(.REG_W(REG_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_status(live_status),
    .cap_time(cap_time), .bus_rdata(bus_rdata), .irq_en(irq_en),
    .ow_allow(ow_allow), .clr_req(clr_req), .snap_take(snap_take),
    .snap_lo(snap_lo), .snap_hi(snap_hi)
  );

  assign irq = st_pend & irq_en;
endmodule

// File: rtl/evt_capture_unit_chk.sv
module evt_capture_unit_chk #(
  parameter int TIME_W = 32,
  parameter int REG_W  = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_edge,
  input logic              clr_req,
  input logic              snap_take,
  input logic              ow_allow,
  input logic              st_pend,
  input logic              st_err,
  input logic [CNT_W-1:0]  st_cnt,
  input logic [TIME_W-1:0] cap_time,
  input logic [REG_W-1:0]  snap_lo,
  input logic [REG_W-1:0]  snap_hi,
  input logic              irq
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_edge |=> !evt_edge);

  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cnt == CMAX && evt_edge && !clr_req) |=> st_cnt == CMAX);

  p_pend_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_edge |=> st_pend);

  p_ow_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_edge && ow_allow && !st_err && !clr_req) |=> !st_err);

  p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pend && evt_edge && !ow_allow && !clr_req) |=> ($stable(cap_time) && st_err));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt_edge) |=> (!st_pend && !st_err && st_cnt == '0));

  p_snap_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> ($stable(snap_lo) && $stable(snap_hi)));

  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt_edge) |=> !irq);
endmodule

bind evt_capture_unit evt_capture_unit_chk #(
  .TIME_W(TIME_W), .REG_W(REG_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_edge(evt_edge), .clr_req(clr_req),
  .snap_take(snap_take), .ow_allow(ow_allow), .st_pend(st_pend),
  .st_err(st_err), .st_cnt(st_cnt), .cap_time(cap_time),
  .snap_lo(snap_lo), .snap_hi(snap_hi), .irq(irq)
);

// File: tb/evt_capture_unit_tb.sv
module evt_capture_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_in = 32'h0001_FF00;
  logic        evt_pin = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the registers
  bit          m_pend, m_err, m_ien, m_ow;
  int          m_cnt;
  logic [31:0] m_time, m_snap;

  evt_capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .time_in(time_in), .evt_pin(evt_pin),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) time_in <= time_in + 32'd3;

  function automatic logic [15:0] exp_status();
    return 16'((int'(m_err) << 9) | (int'(m_pend) << 8) | m_cnt);
  endfunction

  function automatic void model_event(input logic [31:0] t);
    m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
    if (!m_pend || m_ow) begin m_time = t; m_pend = 1'b1; end
    else m_err = 1'b1;
  endfunction

  function automatic void model_clear();
    m_pend = 1'b0; m_err = 1'b0; m_cnt = 0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  // pin high, hold, low; t = time_in during the detection cycle
  task automatic fire_event(input int hold, output logic [31:0] t);
    @(negedge clk); evt_pin = 1;
    @(negedge clk);
    @(negedge clk); t = time_in;
    @(negedge clk);
    repeat (hold) @(negedge clk);
    evt_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_event(input int hold);
    logic [31:0] t;
    fire_event(hold, t);
    model_event(t);
  endtask

  task automatic set_ctrl(input bit ien, input bit ow);
    bus_write(4'h8, {14'h0, ow, ien});
    m_ien = ien; m_ow = ow;
  endtask

  task automatic do_clear();
    bus_write(4'h9, 16'hFFFF);
    model_clear();
  endtask

  task automatic read_triple(input string req);
    logic [15:0] d;
    bus_read(4'h9, d); m_snap = m_time;
    check({req, " status"}, 32'(d), 32'(exp_status()));
    bus_read(4'hA, d); check({req, " time lo"}, 32'(d), 32'(m_snap[15:0]));
    bus_read(4'hB, d); check({req, " time hi"}, 32'(d), 32'(m_snap[31:16]));
  endtask

  task automatic check_irq(input string req);
    @(negedge clk);
    check(req, 32'(irq), 32'(m_pend && m_ien));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d;
    logic [31:0] t;
    void'($urandom(32'h1234_5EED));
    m_pend = 0; m_err = 0; m_cnt = 0; m_ien = 0; m_ow = 0; m_time = 0; m_snap = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    bus_read(4'h8, d); check("R1 ctrl", 32'(d), 0);
    read_triple("R1");

    // R10 control readback and unmapped offsets
    set_ctrl(1, 1);
    bus_read(4'h8, d); check("R10 ctrl readback", 32'(d), 32'h3);
    bus_read(4'h3, d); check("R10 unmapped", 32'(d), 0);

    // R2 R4 R9 first capture, long hold counts once
    do_event(12);
    read_triple("R2 R4 single event");
    check_irq("R9 irq on pending");

    // R5 replacing policy
    do_event(0);
    read_triple("R5 overwrite");

    // R7 R9 clear
    do_clear();
    check_irq("R9 irq after clear");
    read_triple("R7 clear");

    // R6 holding policy
    set_ctrl(0, 0);
    do_event(0); do_event(0); do_event(1);
    read_triple("R6 hold");
    check_irq("R9 irq disabled");
    bus_read(4'h9, d); check("R10 mode bit14", 32'(d[14]), 0);

    // R7 clear and event in the same cycle
    @(negedge clk); evt_pin = 1;
    @(negedge clk);
    @(negedge clk); t = time_in; bus_en = 1; bus_we = 1; bus_addr = 4'h9; bus_wdata = 16'h0;
    @(negedge clk); bus_en = 0; bus_we = 0; evt_pin = 0;
    repeat (3) @(negedge clk);
    model_clear(); model_event(t);
    read_triple("R7 clear with event");

    // R8 shadow coherence across an event
    set_ctrl(1, 1);
    do_clear();
    do_event(0);
    bus_read(4'h9, d); m_snap = m_time;
    check("R8 status", 32'(d), 32'(exp_status()));
    do_event(0);
    bus_read(4'hA, d); check("R8 frozen lo", 32'(d), 32'(m_snap[15:0]));
    do_event(0);
    bus_read(4'hB, d); check("R8 frozen hi", 32'(d), 32'(m_snap[31:16]));
    read_triple("R8 fresh snapshot");

    // R3 saturation in holding policy
    set_ctrl(0, 0);
    do_clear();
    for (int i = 0; i < 258; i++) do_event(0);
    read_triple("R3 saturate");
    do_clear();

    // random mix
    for (int i = 0; i < 80; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0, 1: do_event($urandom_range(0, 3));
        2:    read_triple("R2 R5 R6 random");
        3:    do_clear();
        4:    set_ctrl(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        default: begin
          bus_read(4'h9, d); m_snap = m_time;
          check("R4 random status", 32'(d), 32'(exp_status()));
          do_event(0);
          bus_read(4'hB, d); check("R8 random hi", 32'(d), 32'(m_snap[31:16]));
        end
      endcase
      check_irq("R9 random irq");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule